// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block runs external memory cycles on a 16-bit bus that carries the address first and then the data on the same wires. A request from the core (address, write data, direction, byte or word, and whether it is an instruction fetch) is accepted in one clock. It then runs as an address clock followed by a strobe clock, with optional wait clocks after that. The response is a one-clock done pulse, with the read data held stable afterwards. The width of each cycle is taken from a pin when a configuration bit allows it. A word request on an 8-bit cycle is split into two byte cycles, low address first.

Configuration inputs choose the address-strobe style and the write style. The address strobe is either a short high latch pulse or a low level that lasts for the whole cycle and can serve as a chip select. The write output is either one write strobe plus a byte-high enable, or separate low and high write strobes. A two-bit field caps how many wait clocks the ready input can add. When enabled, a hold input makes the controller give the bus away between cycles. While the bus is away, it reports pending work on a bus-request output.

The sequencer states are IDLE, ADDR, STRB, WAIT and HELD.
- IDLE→ADDR: a pending second byte, or an accepted request.
- IDLE→HELD: hold requested and enabled, with no second byte pending.
- ADDR→STRB: always.
- STRB→WAIT: ready is low and the limit is nonzero.
- STRB→IDLE: otherwise.
- WAIT→IDLE: ready is high or the limit has been reached.
- WAIT→WAIT: otherwise.
- HELD→IDLE: hold dropped or disabled.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset the block is in IDLE with the following outputs:
  - `rd_n`, `wr_n` and `bhe_n` high, `ad_oe` low and `ctl_oe` high.
  - `hold_ack`, `bus_req` and `rsp_done` low, and `req_ready` high.
  - `addr_strobe` at its idle level, which is low in latch style.
- R2: A request is accepted at a clock edge where `req_valid` and `req_ready` are both high. The next clock is the address clock. The clock after that is the strobe clock. `rsp_done` is high for exactly one clock, the clock after the last strobe or wait clock.
- R3: The cycle width is sampled at acceptance. It is 16 bits only when `cfg_wide_en`=1 and `bus_width_in`=1; otherwise it is 8 bits. An 8-bit word request runs two byte cycles, at the address and at the address+1. The first byte lands in `rsp_rdata[7:0]` and the second in `rsp_rdata[15:8]`.
- R4: With `cfg_split_wr`=0, the lane code is (`ad_out[0]` in the address clock, `bhe_n`) and is driven in the address and strobe clocks of 16-bit cycles:
  - (0,1) selects the low byte only.
  - (1,0) selects the high byte only.
  - (0,0) selects both bytes.
  - `bhe_n` stays high on 8-bit cycles, and `wr_n` is low in every write strobe clock.
- R5: With `cfg_split_wr`=1, `wr_n` acts as the low write strobe and goes low only for writes that include the even byte. `bhe_n` acts as the high write strobe and goes low only for writes that include the odd byte. Write data sits on both lanes for byte writes and as the whole word for 16-bit word writes.
- R6: With `cfg_addr_valid`=0, `addr_strobe` is high in the address clock only. With `cfg_addr_valid`=1, it is low from the address clock through the last strobe or wait clock and high otherwise.
- R7: A low `ready_in` at the end of a strobe or wait clock adds a wait clock, up to `cfg_wait_lim` of them per byte cycle. A limit of 0 ignores `ready_in`.
- R8: `fetch_out` is high through the address, strobe and wait clocks of a request flagged as a fetch, and low otherwise.
- R9: When `cfg_hold_en`=1 and `hold_in`=1 in IDLE, `hold_ack` rises on the next clock, and `ad_oe` and `ctl_oe` drop. A cycle already in progress completes first. With `cfg_hold_en`=0, `hold_in` has no effect.
- R10: `hold_ack` falls one clock after `hold_in` is seen low, and `req_ready` returns high at that same clock.
- R11: `bus_req` is high while the bus is held and `req_valid` is high.
- R12: The read strobe `rd_n` and the write strobe `wr_n` are never low together. Read data is taken from `ad_in` at the end of the last strobe or wait clock: the whole word for a 16-bit word read, or the addressed lane for a byte read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one clock per bus state |
| rst_n | input | 1 | Active-low reset |
| cfg_wide_en | input | 1 | Lets `bus_width_in` pick 16-bit cycles |
| cfg_addr_valid | input | 1 | 1: address strobe as a whole-cycle low level; 0: high latch pulse |
| cfg_split_wr | input | 1 | 1: separate low/high write strobes; 0: write plus byte-high enable |
| cfg_wait_lim | input | 2 | Largest number of wait clocks per byte cycle |
| cfg_hold_en | input | 1 | Enables hold, hold-acknowledge and bus request |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this clock |
| req_write | input | 1 | 1 write, 0 read |
| req_word | input | 1 | 1 word (even address), 0 single byte |
| req_fetch | input | 1 | Request is an instruction fetch |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 16 | Write data, byte requests in bits 7:0 |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read data of the last completed request |
| bus_width_in | input | 1 | Per-cycle width pin, high for 16 bits |
| ready_in | input | 1 | Low stretches the cycle |
| hold_in | input | 1 | External request for the bus |
| hold_ack | output | 1 | Bus released |
| bus_req | output | 1 | Work pending while the bus is held |
| ad_in | input | 16 | Address/data bus input |
| ad_out | output | 16 | Address/data bus output |
| ad_oe | output | 1 | Drive enable for `ad_out` |
| ctl_oe | output | 1 | Drive enable for the strobe outputs |
| addr_strobe | output | 1 | Address latch pulse or address-valid level |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe or low write strobe, active low |
| bhe_n | output | 1 | Byte-high enable or high write strobe, active low |
| fetch_out | output | 1 | Instruction-fetch flag |

## Verification
The cycle function is exercised with several request patterns:
- Word and byte reads at even and odd addresses on 16-bit cycles, and 8-bit cycles reached both through the pin and through the configuration bit. The returned data is a function of the address, so a swapped lane or a missed second byte shows up as a wrong value.
- Ready patterns against limits of 0 to 3. Comparing the number of strobe clocks separates an ignored limit, an ignored ready and an off-by-one cap.
- Writes under both write styles, at even and odd bytes and as words. These separate the low and high strobes and the data lanes.
- Both address-strobe styles, and hold applied in IDLE, during a cycle and while disabled. These show the hand-over timing and when bus request is raised.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    typedef enum logic [2:0] {
        XS_IDLE,
        XS_ADDR,
        XS_STRB,
        XS_WAIT,
        XS_HELD
    } xbus_state_e;
endpackage

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int LIM_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              hold_req,
    input  logic              pend,
    input  logic              ready_in,
    input  logic [LIM_W-1:0]  wait_lim,
    output xbus_state_e       state,
    output logic              accept,
    output logic              fin,
    output logic              req_ready
);
    xbus_state_e      nxt;
    logic [LIM_W-1:0] wcnt;

    // next-state and transition strobes
    always_comb begin
        nxt    = state;
        accept = 1'b0;
        fin    = 1'b0;
        unique case (state)
            XS_IDLE: begin
                if (pend) begin
                    nxt = XS_ADDR;
                end else if (hold_req) begin
                    nxt = XS_HELD;
                end else if (req_valid) begin
                    nxt    = XS_ADDR;
                    accept = 1'b1;
                end
            end
            XS_ADDR: nxt = XS_STRB;
            XS_STRB: begin
                if ((wait_lim != '0) && !ready_in) begin
                    nxt = XS_WAIT;
                end else begin
                    nxt = XS_IDLE;
                    fin = 1'b1;
                end
            end
            XS_WAIT: begin
                if (ready_in || (wcnt == wait_lim)) begin
                    nxt = XS_IDLE;
                    fin = 1'b1;
                end
            end
            XS_HELD: if (!hold_req) nxt = XS_IDLE;
            default: nxt = XS_IDLE;
        endcase
    end

    // state register and wait counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= XS_IDLE;
            wcnt  <= '0;
        end else begin
            state <= nxt;
            if (state == XS_STRB)
                wcnt <= {{(LIM_W-1){1'b0}}, 1'b1};
            else if (state == XS_WAIT && !fin)
                wcnt <= wcnt + 1'b1;
        end
    end

    assign req_ready = (state == XS_IDLE) && !pend && !hold_req;
endmodule

// File: rtl/xbus_dpath.sv
module xbus_dpath #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          fin,
    input  logic          wide_sel,
    input  logic          req_write,
    input  logic          req_word,
    input  logic          req_fetch,
    input  logic [DW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] ad_in,
    output logic [DW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output logic          write_q,
    output logic          word_q,
    output logic          fetch_q,
    output logic          wide_q,
    output logic          second_q,
    output logic          cur_a0,
    output logic          rsp_done,
    output logic [DW-1:0] rsp_rdata
);
    localparam int HB = DW / 2;

    logic split;
    assign split  = word_q && !wide_q;
    assign cur_a0 = (wide_q && word_q) ? 1'b0 : (addr_q[0] | second_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            wdata_q   <= '0;
            write_q   <= 1'b0;
            word_q    <= 1'b0;
            fetch_q   <= 1'b0;
            wide_q    <= 1'b0;
            second_q  <= 1'b0;
            rsp_done  <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_done <= 1'b0;
            if (accept) begin
                addr_q    <= req_addr;
                wdata_q   <= req_wdata;
                write_q   <= req_write;
                word_q    <= req_word;
                fetch_q   <= req_fetch;
                wide_q    <= wide_sel;
                second_q  <= 1'b0;
                rsp_rdata <= '0;
            end else if (fin) begin
                if (split && !second_q) second_q <= 1'b1;
                else begin
                    second_q <= 1'b0;
                    rsp_done <= 1'b1;
                end
                if (!write_q) begin
                    if (wide_q) begin
                        if (word_q)         rsp_rdata <= ad_in;
                        else if (addr_q[0]) rsp_rdata <= {{HB{1'b0}}, ad_in[DW-1:HB]};
                        else                rsp_rdata <= {{HB{1'b0}}, ad_in[HB-1:0]};
                    end else if (second_q) begin
                        rsp_rdata[DW-1:HB] <= ad_in[HB-1:0];
                    end else begin
                        rsp_rdata[HB-1:0] <= ad_in[HB-1:0];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/xbus_lanes.sv
module xbus_lanes
    import xbus_pkg::*;
#(
    parameter int DW = 16
) (
    input  xbus_state_e   state,
    input  logic [DW-2:0] addr_hi,
    input  logic [DW-1:0] wdata_q,
    input  logic          cur_a0,
    input  logic          write_q,
    input  logic          word_q,
    input  logic          wide_q,
    input  logic          fetch_q,
    input  logic          second_q,
    input  logic          cfg_split_wr,
    input  logic          cfg_addr_valid,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe,
    output logic          ctl_oe,
    output logic          addr_strobe,
    output logic          rd_n,
    output logic          wr_n,
    output logic          bhe_n,
    output logic          fetch_out
);
    localparam int HB = DW / 2;

    logic          phase, busy, lane_lo, lane_hi;
    logic [HB-1:0] wbyte;
    logic [DW-1:0] wdrive;

    assign lane_lo = !cur_a0;
    assign lane_hi = wide_q ? (word_q | cur_a0) : cur_a0;
    assign wbyte   = second_q ? wdata_q[DW-1:HB] : wdata_q[HB-1:0];
    assign wdrive  = (wide_q && word_q) ? wdata_q : {wbyte, wbyte};

    // output decode
    always_comb begin
        phase = 1'b0;
        busy  = 1'b0;
        unique case (state)
            XS_ADDR:          busy = 1'b1;
            XS_STRB, XS_WAIT: begin busy = 1'b1; phase = 1'b1; end
            XS_IDLE, XS_HELD: ;
            default:          ;
        endcase
        ad_out      = '0;
        if (state == XS_ADDR)        ad_out = {addr_hi, cur_a0};
        else if (phase && write_q)   ad_out = wdrive;
        ad_oe       = (state == XS_ADDR) || (phase && write_q);
        ctl_oe      = (state != XS_HELD);
        addr_strobe = cfg_addr_valid ? !busy : (state == XS_ADDR);
        rd_n        = !(phase && !write_q);
        if (cfg_split_wr) begin
            wr_n  = !(phase && write_q && lane_lo);
            bhe_n = !(phase && write_q && lane_hi);
        end else begin
            wr_n  = !(phase && write_q);
            bhe_n = !(busy && wide_q && lane_hi);
        end
        fetch_out = busy && fetch_q;
    end
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int DW    = 16,
    parameter int LIM_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wide_en,
    input  logic             cfg_addr_valid,
    input  logic             cfg_split_wr,
    input  logic [LIM_W-1:0] cfg_wait_lim,
    input  logic             cfg_hold_en,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic             req_word,
    input  logic             req_fetch,
    input  logic [DW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             rsp_done,
    output logic [DW-1:0]    rsp_rdata,
    input  logic             bus_width_in,
    input  logic             ready_in,
    input  logic             hold_in,
    output logic             hold_ack,
    output logic             bus_req,
    input  logic [DW-1:0]    ad_in,
    output logic [DW-1:0]    ad_out,
    output logic             ad_oe,
    output logic             ctl_oe,
    output logic             addr_strobe,
    output logic             rd_n,
    output logic             wr_n,
    output logic             bhe_n,
    output logic             fetch_out
);
    xbus_state_e   state;
    logic          accept, fin, hold_req;
    logic [DW-1:0] addr_q, wdata_q;
    logic          write_q, word_q, fetch_q, wide_q, second_q, cur_a0;

    assign hold_req = cfg_hold_en && hold_in;
    assign hold_ack = (state == XS_HELD);
    assign bus_req  = (state == XS_HELD) && req_valid;

    xbus_seq #(.LIM_W(LIM_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .hold_req(hold_req),
        .pend(second_q), .ready_in(ready_in), .wait_lim(cfg_wait_lim),
        .state(state), .accept(accept), .fin(fin), .req_ready(req_ready)
    );

    xbus_dpath #(.DW(DW)) u_dpath (
        .clk(clk), .rst_n(rst_n), .accept(accept), .fin(fin),
        .wide_sel(cfg_wide_en && bus_width_in), .req_write(req_write),
        .req_word(req_word), .req_fetch(req_fetch), .req_addr(req_addr),
        .req_wdata(req_wdata), .ad_in(ad_in), .addr_q(addr_q), .wdata_q(wdata_q),
        .write_q(write_q), .word_q(word_q), .fetch_q(fetch_q), .wide_q(wide_q),
        .second_q(second_q), .cur_a0(cur_a0), .rsp_done(rsp_done),
        .rsp_rdata(rsp_rdata)
    );

    xbus_lanes #(.DW(DW)) u_lanes (
        .state(state), .addr_hi(addr_q[DW-1:1]), .wdata_q(wdata_q),
        .cur_a0(cur_a0), .write_q(write_q), .word_q(word_q), .wide_q(wide_q),
        .fetch_q(fetch_q), .second_q(second_q), .cfg_split_wr(cfg_split_wr),
        .cfg_addr_valid(cfg_addr_valid), .ad_out(ad_out), .ad_oe(ad_oe),
        .ctl_oe(ctl_oe), .addr_strobe(addr_strobe), .rd_n(rd_n), .wr_n(wr_n),
        .bhe_n(bhe_n), .fetch_out(fetch_out)
    );
endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk #(
    parameter int LIM_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_addr_valid,
    input logic [LIM_W-1:0] cfg_wait_lim,
    input logic             hold_in,
    input logic             hold_ack,
    input logic             rd_n,
    input logic             wr_n,
    input logic             addr_strobe,
    input logic             ad_oe,
    input logic             ctl_oe,
    input logic             rsp_done
);
    logic [LIM_W+1:0] rd_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_run <= '0;
        else if (!rd_n) rd_run <= rd_run + 1'b1;
        else            rd_run <= '0;
    end

    assert_rd_wr_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    assert_wait_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_run <= ({2'b00, cfg_wait_lim} + 1'b1));

    assert_valid_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr_valid && !rd_n) |-> !addr_strobe);

    assert_hold_float_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack |-> (!ad_oe && !ctl_oe));

    assert_hold_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hold_in) && hold_ack) |=> !hold_ack);

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
endmodule

bind xbus_ctrl xbus_ctrl_chk #(.LIM_W(LIM_W)) u_chk (.*);

// File: tb/xbus_ctrl_test.sv
`timescale 1ns/100ps
module xbus_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wide_en = 0, cfg_addr_valid = 0, cfg_split_wr = 0, cfg_hold_en = 0;
    logic [1:0]  cfg_wait_lim = 0;
    logic        req_valid = 0, req_write = 0, req_word = 0, req_fetch = 0;
    logic [15:0] req_addr = 0, req_wdata = 0, ad_in = 0;
    logic        bus_width_in = 0, ready_in = 1, hold_in = 0;
    logic        req_ready, rsp_done, hold_ack, bus_req, ad_oe, ctl_oe;
    logic        addr_strobe, rd_n, wr_n, bhe_n, fetch_out;
    logic [15:0] rsp_rdata, ad_out;
    int nchk = 0, nfail = 0;

    always #2.5 clk = ~clk;

    xbus_ctrl uut (.*);

    typedef struct packed {
        logic        wen, bw, split, valid;
        logic [1:0]  lim;
        logic        wr, word, fetch;
        logic [15:0] addr, wdata;
        logic [1:0]  rdy;
        logic [3:0]  nstb;
        logic        ewr, ebhe;
        logic [15:0] edata;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VT [NV] = '{
        '{1,1,0,0,2'd0,0,1,0,16'h1234,16'h0000,2'd0,4'd1,1,0,16'h0908},
        '{1,1,0,0,2'd2,0,0,0,16'h2001,16'h0000,2'd1,4'd2,1,0,16'h003D},
        '{1,1,0,0,2'd3,0,0,0,16'h2002,16'h0000,2'd3,4'd4,1,1,16'h003E},
        '{1,1,0,0,2'd1,0,0,0,16'h0040,16'h0000,2'd3,4'd2,1,1,16'h007C},
        '{1,1,0,0,2'd0,0,1,0,16'h0100,16'h0000,2'd2,4'd1,1,0,16'h3D3C},
        '{1,0,0,0,2'd0,0,1,0,16'h0456,16'h0000,2'd0,4'd2,1,1,16'h6B6A},
        '{0,1,0,0,2'd1,0,1,0,16'h0010,16'h0000,2'd1,4'd4,1,1,16'h2D2C},
        '{1,1,0,0,2'd0,1,1,0,16'h3000,16'hBEEF,2'd0,4'd1,0,0,16'hBEEF},
        '{1,1,0,0,2'd0,1,0,0,16'h3001,16'h00A7,2'd0,4'd1,0,0,16'hA7A7},
        '{1,1,1,0,2'd0,1,0,0,16'h3002,16'h0055,2'd0,4'd1,0,1,16'h5555},
        '{1,1,1,0,2'd0,1,0,0,16'h3003,16'h0066,2'd0,4'd1,1,0,16'h6666},
        '{1,1,1,0,2'd0,1,1,0,16'h3004,16'h1234,2'd0,4'd1,0,0,16'h1234},
        '{1,0,1,0,2'd0,1,1,0,16'h3006,16'hCAFE,2'd0,4'd2,0,1,16'hFEFE},
        '{1,1,0,1,2'd0,0,1,1,16'h2080,16'h0000,2'd0,4'd1,1,0,16'hBDBC},
        '{0,0,0,0,2'd2,0,0,1,16'h0077,16'h0000,2'd0,4'd1,1,1,16'h004B},
        '{1,1,1,1,2'd2,1,0,0,16'h3009,16'h0011,2'd2,4'd3,1,0,16'h1111}
    };

    function automatic logic [7:0] mem(input logic [15:0] a);
        return a[7:0] ^ 8'h3C;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive_mem(input logic narrow, input logic [15:0] a);
        ad_in = narrow ? {8'h00, mem(a)}
                       : {mem({a[15:1], 1'b1}), mem({a[15:1], 1'b0})};
    endtask

    task automatic run_vec(input vec_t v);
        int   strobes = 0, lowcnt = 0;
        logic first = 1'b1, got = 1'b0, ph;
        logic narrow = !(v.wen && v.bw);
        @(negedge clk);
        cfg_wide_en = v.wen; bus_width_in = v.bw; cfg_split_wr = v.split;
        cfg_addr_valid = v.valid; cfg_wait_lim = v.lim;
        req_write = v.wr; req_word = v.word; req_fetch = v.fetch;
        req_addr = v.addr; req_wdata = v.wdata; req_valid = 1'b1;
        chk("R2 ready before accept", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R4 address clock ad_out", ad_out, v.addr);
        chk("R6 strobe in address clock", addr_strobe, !v.valid);
        chk("R8 fetch in address clock", fetch_out, v.fetch);
        drive_mem(narrow, ad_out);
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (rsp_done) begin got = 1'b1; break; end
            ph = !rd_n || !wr_n || (v.split && !bhe_n);
            if (ph) begin
                strobes++; lowcnt++;
                if (first) begin
                    chk("R12 rd_n in strobe", rd_n, v.wr);
                    chk("R5 wr_n in strobe", wr_n, v.ewr);
                    chk("R4 bhe_n in strobe", bhe_n, v.ebhe);
                    chk("R6 strobe level in strobe", addr_strobe, 0);
                    if (v.wr) chk("R5 write data", ad_out, v.edata);
                    first = 1'b0;
                end
                ready_in = (lowcnt > v.rdy);
            end else if (ad_oe) begin
                drive_mem(narrow, ad_out);
                lowcnt = 0;
            end
        end
        chk("R2 done seen", got, 1);
        chk("R7 R3 strobe clocks", strobes, v.nstb);
        chk("R6 idle strobe level", addr_strobe, v.valid);
        if (!v.wr) chk("R3 R12 read data", rsp_rdata, v.edata);
        ready_in = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset outputs",
            {rd_n, wr_n, bhe_n, ad_oe, ctl_oe, hold_ack, bus_req, rsp_done, req_ready, addr_strobe},
            10'b1110100010);

        for (int i = 0; i < NV; i++) run_vec(VT[i]);

        // hold ignored while disabled
        cfg_hold_en = 1'b0; hold_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R9 hold ignored when disabled", {hold_ack, ctl_oe, req_ready}, 3'b011);
        hold_in = 1'b0;

        // hold arriving during a cycle
        cfg_hold_en = 1'b1; cfg_wide_en = 1; bus_width_in = 1; cfg_split_wr = 0;
        cfg_addr_valid = 0; cfg_wait_lim = 0;
        req_write = 0; req_word = 1; req_fetch = 0; req_addr = 16'h0200; req_valid = 1;
        @(negedge clk);
        req_valid = 0; hold_in = 1;
        drive_mem(1'b0, 16'h0200);
        @(negedge clk);
        chk("R9 cycle finishes under hold", {hold_ack, rd_n}, 2'b00);
        @(negedge clk);
        chk("R9 done before release of bus", {rsp_done, hold_ack}, 2'b10);
        chk("R12 read under hold", rsp_rdata, 16'h3D3C);
        @(negedge clk);
        chk("R9 bus floated", {hold_ack, ad_oe, ctl_oe, req_ready}, 4'b1000);
        req_valid = 1;
        @(negedge clk);
        chk("R11 bus request while held", {bus_req, hold_ack}, 2'b11);
        hold_in = 0;
        @(negedge clk);
        chk("R10 acknowledge drops", {hold_ack, bus_req, req_ready, ctl_oe}, 4'b0011);
        req_valid = 0;
        @(negedge clk);
        chk("R11 no request when idle", bus_req, 0);

        // hold entry from idle
        hold_in = 1;
        @(negedge clk);
        chk("R9 acknowledge next clock", hold_ack, 1);
        chk("R11 no request without work", bus_req, 0);
        hold_in = 0;
        @(negedge clk);
        chk("R10 release after one clock", {hold_ack, req_ready}, 2'b01);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule